// File: doc/BRIEF.md
# JTAG Console Byte Exchanger

This block moves console bytes between a debug host and a target in both directions during one data-register shift. It sits between the debug shift path (capture strobe, shift enable, serial in, serial out) and two small byte FIFOs: one that feeds received bytes to the target and one that holds bytes waiting for the host. A frame opens with a count byte. The host shifts in its write count while the block shifts out, at the same time, how many bytes the host may read and how many it may write. Up to eight data bytes then follow in each direction, least significant bit first.

The counts reported to the host are latched when the shift is captured. The block writes into the target FIFO only the bytes that fit the smaller of the host's count and the free space, and it drops the rest. It pops the host-side FIFO only for bytes whose eight bits have all left on the serial output. When the shift path sits in a chain of several devices, an optional mode makes the block wait for a leading 1 before the count byte. Any bits after the last data slot, such as a trailing stop bit, have no effect.

Top module: `jsx_exchanger`

## Requirements
- R1: After reset and before the first capture, tdo, tx_pop and rx_push are 0, and shifting has no effect.
- R2: A capture latches A = min(tx_level, 8) and F = min(rx_space, 8). The first eight frame bits on tdo form the status byte {A[3:0], F[3:0]} (A in bits 7:4, F in bits 3:0), sent bit 0 first.
- R3: The host write count W is bits 7:4 of the first frame byte received, with bit 0 arriving first. Bits 3:0 of that byte are ignored, and a W above 8 counts as 8.
- R4: At most eight data bytes follow the count byte in each direction. Bits shifted after the 64th data bit leave tdo at 0 and cause no push and no pop.
- R5: Only the first min(W, F) data bytes are written to the target FIFO; any further host bytes are discarded.
- R6: While data byte k (0-based) is shifting, tdo carries tx_head bit by bit, bit 0 first, when k < A, and 0 otherwise.
- R7: When lead_start_en is 1 at capture, bits up to and including the first 1 on tdi are skipped and tdo stays 0 during them; the count byte starts on the next bit.
- R8: rx_push is a one-cycle pulse in the cycle after the clock edge that takes the 8th bit of an accepted byte, and rx_byte then holds that byte. A partly shifted byte is never pushed.
- R9: tx_pop is high, combinationally, during the shift cycle whose edge takes the 8th bit of a data byte k < A. A byte that is only partly shifted out is never popped.
- R10: A capture in the middle of a frame abandons that frame and starts a new one with freshly latched counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| lead_start_en | input | 1 | Multi-device mode: wait for a leading 1 before the count byte |
| dr_capture | input | 1 | Frame start strobe (capture of the data register) |
| dr_shift | input | 1 | One serial bit is taken on each edge while high |
| tdi | input | 1 | Serial data from the host |
| tdo | output | 1 | Serial data to the host, valid for the bit taken at the next edge |
| tx_level | input | CW | Fill level of the host-bound FIFO |
| tx_head | input | 8 | Head byte of the host-bound FIFO |
| tx_pop | output | 1 | Pop strobe for the host-bound FIFO |
| rx_space | input | CW | Free entries in the target-bound FIFO |
| rx_push | output | 1 | Push strobe for the target-bound FIFO |
| rx_byte | output | 8 | Byte written with rx_push |

## Verification
tdo and tx_pop are combinational. They are due in the same cycle as the bit they describe, so the bench drives inputs on the falling edge and compares both outputs one time step later, before the rising edge that takes the bit. rx_push and rx_byte are registered and are due one cycle after the edge that takes a byte's last bit. The reference model holds that result as a pending value and compares it at the next falling edge. The host-bound queue in the bench advances just after each rising edge, so tx_head changes only between bits, as a real FIFO would.

// File: rtl/jsx_pkg.sv
package jsx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_HUNT,
    PH_COUNT,
    PH_DATA,
    PH_DONE
  } jsx_phase_e;

  // Saturate a count to a limit and return it as a nibble.
  function automatic logic [3:0] clamp_nib(input int unsigned val, input int unsigned lim);
    int unsigned r;
    r = (val > lim) ? lim : val;
    return r[3:0];
  endfunction

  // Bytes the block takes: smaller of the host count (saturated) and the room.
  function automatic logic [3:0] accept_count(input logic [3:0] want, input logic [3:0] room,
                                              input int unsigned lim);
    logic [3:0] w;
    w = clamp_nib(32'(want), lim);
    return (w < room) ? w : room;
  endfunction

endpackage

// File: rtl/jsx_frame_ctrl.sv
module jsx_frame_ctrl
  import jsx_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int BIDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lead_start_en,
  input  logic              dr_capture,
  input  logic              dr_shift,
  input  logic              tdi,
  output logic              in_hunt,
  output logic              in_count,
  output logic              in_data,
  output logic              in_done,
  output logic              take_bit,
  output logic              count_end,
  output logic              data_byte_end,
  output logic [2:0]        bit_idx,
  output logic [BIDX_W-1:0] byte_idx
);

  localparam logic [BIDX_W-1:0] LAST_BYTE = BIDX_W'(MAX_BYTES - 1);

  jsx_phase_e phase;
  logic       take;

  assign take          = dr_shift && !dr_capture;
  assign in_hunt       = (phase == PH_HUNT);
  assign in_count      = (phase == PH_COUNT);
  assign in_data       = (phase == PH_DATA);
  assign in_done       = (phase == PH_DONE);
  assign take_bit      = take && (in_count || in_data);
  assign count_end     = take && in_count && (bit_idx == 3'd7);
  assign data_byte_end = take && in_data && (bit_idx == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      bit_idx  <= '0;
      byte_idx <= '0;
    end else if (dr_capture) begin
      phase    <= lead_start_en ? PH_HUNT : PH_COUNT;
      bit_idx  <= '0;
      byte_idx <= '0;
    end else if (dr_shift) begin
      unique case (phase)
        PH_HUNT:  if (tdi) phase <= PH_COUNT;
        PH_COUNT: begin
          bit_idx <= bit_idx + 3'd1;
          if (bit_idx == 3'd7) phase <= PH_DATA;
        end
        PH_DATA: begin
          bit_idx <= bit_idx + 3'd1;
          if (bit_idx == 3'd7) begin
            byte_idx <= byte_idx + 1'b1;
            if (byte_idx == LAST_BYTE) phase <= PH_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  // R7: the first 1 seen while hunting opens the count byte at bit 0
  assert_hunt_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hunt && dr_shift && !dr_capture && tdi) |=> (in_count && bit_idx == 3'd0));

  // R10: a capture always restarts the frame counters
  assert_capture_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dr_capture |=> (bit_idx == 3'd0 && byte_idx == '0 && !in_data && !in_done));

endmodule

// File: rtl/jsx_rx_path.sv
module jsx_rx_path
  import jsx_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int BIDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              take_bit,
  input  logic              tdi,
  input  logic              count_end,
  input  logic              data_byte_end,
  input  logic [BIDX_W-1:0] byte_idx,
  input  logic [3:0]        free_q,
  output logic              rx_push,
  output logic [7:0]        rx_byte
);

  logic [7:0] sr;
  logic [7:0] next_byte;
  logic [3:0] accept_q;
  logic [3:0] push_cnt;
  logic       byte_taken;

  assign next_byte  = {tdi, sr[7:1]};
  assign byte_taken = data_byte_end && (4'(byte_idx) < accept_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr       <= '0;
      accept_q <= '0;
      rx_push  <= 1'b0;
      rx_byte  <= '0;
      push_cnt <= '0;
    end else begin
      rx_push <= byte_taken;
      if (take_bit) sr <= next_byte;
      if (frame_start) accept_q <= '0;
      else if (count_end) accept_q <= accept_count(next_byte[7:4], free_q, MAX_BYTES);
      if (byte_taken) rx_byte <= next_byte;
      if (frame_start) push_cnt <= '0;
      else if (rx_push) push_cnt <= push_cnt + 4'd1;
    end
  end

  // R8: a push follows the edge that completed a data byte
  assert_push_after_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> $past(data_byte_end));

  // R5: never more pushes in a frame than the accepted count
  assert_push_within_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (push_cnt < accept_q));

endmodule

// File: rtl/jsx_tx_path.sv
module jsx_tx_path
  import jsx_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int BIDX_W    = 4,
  parameter int CW        = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [CW-1:0]     tx_level,
  input  logic [CW-1:0]     rx_space,
  input  logic [7:0]        tx_head,
  input  logic              in_count,
  input  logic              in_data,
  input  logic              data_byte_end,
  input  logic [2:0]        bit_idx,
  input  logic [BIDX_W-1:0] byte_idx,
  output logic [3:0]        free_q,
  output logic              tdo,
  output logic              tx_pop
);

  logic [3:0] avail_q;
  logic [3:0] pop_cnt;
  logic [7:0] status;
  logic       byte_ok;

  assign status  = {avail_q, free_q};
  assign byte_ok = 4'(byte_idx) < avail_q;
  assign tx_pop  = data_byte_end && byte_ok;

  always_comb begin
    if (in_count)                tdo = status[bit_idx];
    else if (in_data && byte_ok) tdo = tx_head[bit_idx];
    else                         tdo = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q <= '0;
      free_q  <= '0;
      pop_cnt <= '0;
    end else if (frame_start) begin
      avail_q <= clamp_nib(32'(tx_level), MAX_BYTES);
      free_q  <= clamp_nib(32'(rx_space), MAX_BYTES);
      pop_cnt <= '0;
    end else if (tx_pop) begin
      pop_cnt <= pop_cnt + 4'd1;
    end
  end

  // R9: never more pops in a frame than bytes reported available
  assert_pop_within_avail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (pop_cnt < avail_q));

endmodule

// File: rtl/jsx_exchanger.sv
module jsx_exchanger
  import jsx_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int CW        = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lead_start_en,
  input  logic          dr_capture,
  input  logic          dr_shift,
  input  logic          tdi,
  output logic          tdo,
  input  logic [CW-1:0] tx_level,
  input  logic [7:0]    tx_head,
  output logic          tx_pop,
  input  logic [CW-1:0] rx_space,
  output logic          rx_push,
  output logic [7:0]    rx_byte
);

  localparam int BIDX_W = $clog2(MAX_BYTES + 1);

  logic              in_hunt, in_count, in_data, in_done;
  logic              take_bit, count_end, data_byte_end;
  logic [2:0]        bit_idx;
  logic [BIDX_W-1:0] byte_idx;
  logic [3:0]        free_q;

  jsx_frame_ctrl #(.MAX_BYTES(MAX_BYTES), .BIDX_W(BIDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .lead_start_en(lead_start_en),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .tdi(tdi),
    .in_hunt(in_hunt), .in_count(in_count), .in_data(in_data), .in_done(in_done),
    .take_bit(take_bit), .count_end(count_end), .data_byte_end(data_byte_end),
    .bit_idx(bit_idx), .byte_idx(byte_idx)
  );

  jsx_rx_path #(.MAX_BYTES(MAX_BYTES), .BIDX_W(BIDX_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .frame_start(dr_capture), .take_bit(take_bit),
    .tdi(tdi), .count_end(count_end), .data_byte_end(data_byte_end),
    .byte_idx(byte_idx), .free_q(free_q), .rx_push(rx_push), .rx_byte(rx_byte)
  );

  jsx_tx_path #(.MAX_BYTES(MAX_BYTES), .BIDX_W(BIDX_W), .CW(CW)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_start(dr_capture), .tx_level(tx_level),
    .rx_space(rx_space), .tx_head(tx_head), .in_count(in_count), .in_data(in_data),
    .data_byte_end(data_byte_end), .bit_idx(bit_idx), .byte_idx(byte_idx),
    .free_q(free_q), .tdo(tdo), .tx_pop(tx_pop)
  );

  // R4: after the last data slot the serial output stays quiet and nothing pops
  assert_quiet_after_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_done |-> (!tdo && !tx_pop));

  // R7: while hunting for the start bit nothing is driven or moved
  assert_quiet_while_hunting_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_hunt |-> (!tdo && !tx_pop && !$rose(rx_push)));

endmodule

// File: tb/test_jsx_exchanger.sv
`timescale 1ns/1ps
module test_jsx_exchanger;

  localparam int CW   = 5;
  localparam int MAXB = 8;
  localparam int LAST = 8 + 8 * MAXB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lead_start_en = 1'b0, dr_capture = 1'b0, dr_shift = 1'b0, tdi = 1'b0;
  logic          tdo, tx_pop, rx_push;
  logic [CW-1:0] tx_level = '0, rx_space = '0;
  logic [7:0]    tx_head = '0, rx_byte;

  int checks = 0, fails = 0;

  // reference model state
  logic [7:0] txq[$];
  logic [7:0] hb[MAXB];
  bit   m_active = 0, m_hunt = 0;
  int   m_pos = 0, m_avail = 0, m_free = 0, m_accept = 0;
  int   m_asm = 0;
  bit   m_pend = 0;
  int   m_pend_byte = 0;
  bit   m_pop = 0;
  int   space_v = 0;
  string scen = "";

  always #5 clk = ~clk;

  jsx_exchanger #(.MAX_BYTES(MAXB), .CW(CW)) i_jsx_exchanger (
    .clk(clk), .rst_n(rst_n), .lead_start_en(lead_start_en), .dr_capture(dr_capture),
    .dr_shift(dr_shift), .tdi(tdi), .tdo(tdo), .tx_level(tx_level), .tx_head(tx_head),
    .tx_pop(tx_pop), .rx_space(rx_space), .rx_push(rx_push), .rx_byte(rx_byte)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, scen, act, exp);
    end
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic refresh_fifo();
    tx_level = CW'(txq.size());
    tx_head  = (txq.size() > 0) ? txq[0] : 8'h00;
    rx_space = CW'(space_v);
  endtask

  // One clock: drive at the falling edge, compare, advance the model, then
  // let the host-bound queue move just after the rising edge.
  task automatic step(input bit cap, input bit sh, input bit din);
    int exp_tdo, k, b;
    string tag;
    @(negedge clk);
    dr_capture = cap; dr_shift = sh; tdi = din;
    #1;
    exp_tdo = 0; tag = "R1"; m_pop = 0;
    k = (m_pos - 8) / 8; b = (m_pos - 8) % 8;
    if (m_active && m_hunt) tag = "R7";
    else if (m_active && m_pos < 8) begin
      tag = "R2"; exp_tdo = (((m_avail << 4) | m_free) >> m_pos) & 1;
    end else if (m_active && m_pos < LAST) begin
      tag = "R6";
      if (k < m_avail) exp_tdo = txq[0][b];
      m_pop = sh && !cap && (b == 7) && (k < m_avail);
    end else if (m_active) tag = "R4";
    check({tag, " tdo"}, tdo, exp_tdo);
    check("R9 tx_pop", tx_pop, m_pop);
    check("R3 R5 R8 rx_push", rx_push, m_pend);
    if (m_pend) check("R8 rx_byte", rx_byte, m_pend_byte);
    m_pend = 0;
    if (cap) begin
      m_active = 1; m_hunt = lead_start_en; m_pos = 0; m_asm = 0; m_accept = 0;
      m_avail = imin(txq.size(), MAXB); m_free = imin(space_v, MAXB);
    end else if (sh && m_active) begin
      if (m_hunt) begin
        if (din) m_hunt = 0;
      end else if (m_pos < LAST) begin
        m_asm = (m_asm >> 1) | (int'(din) << 7);
        if (m_pos == 7) m_accept = imin(imin(m_asm >> 4, MAXB), m_free);
        if (m_pos >= 8 && b == 7 && k < m_accept) begin
          m_pend = 1; m_pend_byte = m_asm;
        end
        m_pos++;
      end
    end
    @(posedge clk);
    #1;
    if (m_pop) void'(txq.pop_front());
    refresh_fifo();
  endtask

  // Frame: capture, optional zeros and start bit, count byte, data bits, tail bits.
  task automatic frame(input bit lead, input int zeros, input logic [7:0] cnt,
                       input int nbits, input int tail);
    lead_start_en = lead;
    step(1, 0, 0);
    if (lead) begin
      for (int i = 0; i < zeros; i++) step(0, 1, 0);
      step(0, 1, 1);
    end
    for (int i = 0; i < 8; i++) step(0, 1, cnt[i]);
    for (int i = 0; i < nbits; i++) step(0, 1, hb[i / 8][i % 8]);
    for (int i = 0; i < tail; i++) step(0, 1, 0);
    step(0, 0, 0);
  endtask

  task automatic load(input int n, input int seed);
    txq.delete();
    for (int i = 0; i < n; i++) txq.push_back(8'(seed + 37 * i) ^ 8'h5A);
    for (int i = 0; i < MAXB; i++) hb[i] = 8'(seed * 3 + 29 * i) ^ 8'hC3;
    refresh_fifo();
  endtask

  initial begin
    #1500000;
    fails++; checks++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    refresh_fifo();
    #22;
    // R1: quiet outputs while held in reset
    check("R1 reset tdo", tdo, 0);
    check("R1 reset tx_pop", tx_pop, 0);
    check("R1 reset rx_push", rx_push, 0);
    rst_n = 1'b1;
    scen = "idle";
    load(3, 1); space_v = 6; refresh_fifo();
    for (int i = 0; i < 6; i++) step(0, 1, i[0]);          // R1: shifts before capture
    scen = "basic";
    space_v = 5; load(2, 7); refresh_fifo();
    frame(0, 0, 8'h3F, 64, 1);                              // R3 low nibble ignored, stop bit R4
    scen = "clamp";
    space_v = 2; load(12, 19); refresh_fifo();
    frame(0, 0, 8'h80, 64, 3);                              // R2 avail clamp, R5 extras dropped
    scen = "bigcount";
    space_v = 20; load(9, 44); refresh_fifo();
    frame(0, 0, 8'hF0, 64, 0);                              // R3 count above 8 saturates
    scen = "R7 lead";
    space_v = 8; load(3, 61); refresh_fifo();
    frame(1, 3, 8'h45, 64, 1);
    scen = "R10 abort";
    space_v = 8; load(4, 90); refresh_fifo();
    frame(0, 0, 8'h40, 13, 0);                              // partial second byte not pushed/popped
    frame(0, 0, 8'h20, 64, 0);
    scen = "empty";
    space_v = 0; load(0, 5); refresh_fifo();
    frame(0, 0, 8'h50, 64, 2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule